// File: doc/BRIEF.md
# TLP Transmit Beat Packer

This block turns PCI Express transaction layer packets into 64-bit beats for a streaming transmit port. Each packet carries a four-dword header and a payload of 1 to 64 dwords. An upstream request port offers the packet descriptor, which holds the header, an alignment flag and a length. A separate payload port delivers payload dwords two at a time. The block sends two header beats and then the data beats. When the packet's address is not qword aligned, the first data beat carries a padding dword in its low half.

The transmit sink signals readiness two cycles before the beat it applies to. The block asserts valid only in a cycle whose ready was sampled high two cycles earlier. At any other time it holds its position in the packet. It stalls the payload source in the same cycles. A waiting packet starts on the cycle right after the previous end-of-packet beat, so back-to-back packets have no idle cycle between them.

Top module: `tlp_tx_pack`

## Requirements
- R1: The first beat of a packet has `tx_sop` high and carries header dword 0 in bits 31:0 and header dword 1 in bits 63:32. Header dword i enters on `req_hdr[32i+31:32i]`.
- R2: The second beat carries header dword 2 in bits 31:0 and header dword 3 in bits 63:32. It has neither `tx_sop` nor `tx_eop` set.
- R3: With `req_misaligned` low, data beat k carries payload dword 2k low and dword 2k+1 high. If the length is odd, the high half of the last beat is zero.
- R4: With `req_misaligned` high, the first data beat has payload dword 0 in bits 63:32 and zero in bits 31:0. Data beat k≥1 carries dword 2k-1 low and dword 2k high. A high half beyond the length is zero.
- R5: `tx_sop` marks only the first header beat. `tx_eop` marks only the beat holding the last payload dword.
- R6: `tx_valid` is high only in a cycle where `tx_ready` was high two cycles earlier. No beat appears in the first two cycles after reset.
- R7: A beat that cannot be sent because of backpressure or a payload stall is kept and sent later. Beats are never lost, duplicated or reordered.
- R8: With ready and payload continuously available and a request waiting, the next packet's start-of-packet beat follows the end-of-packet beat in the very next cycle.
- R9: `req_ready` is high only when no packet is in progress, or in the cycle the last beat of the current packet is sent.
- R10: A payload pair is taken (`pay_valid` and `pay_ready` both high) only in a cycle in which a data beat is sent. Bits 31:0 of `pay_data` hold the earlier dword.
- R11: During and right after reset, `tx_valid` and `pay_ready` are low and `req_ready` is high.
- R12: `req_len` lies between 1 and 64 while `req_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Packet descriptor offered |
| req_ready | output | 1 | Descriptor taken this cycle when valid |
| req_hdr | input | 128 | Header dwords 0..3, dword i at bits 32i+31:32i |
| req_misaligned | input | 1 | Address is not qword aligned |
| req_len | input | 7 | Payload length in dwords, 1..64 |
| pay_valid | input | 1 | Payload pair offered |
| pay_ready | output | 1 | Payload pair taken this cycle |
| pay_data | input | 64 | Payload pair, earlier dword in bits 31:0 |
| tx_ready | input | 1 | Sink ready, applies two cycles later |
| tx_valid | output | 1 | Beat presented and accepted |
| tx_sop | output | 1 | First beat of a packet |
| tx_eop | output | 1 | Last beat of a packet |
| tx_data | output | 64 | Beat data |

## Verification
If the remaining-dword count or the first-beat flag goes wrong, the next data beat shows a misplaced or wrong dword. The end-of-packet mark also lands on the wrong beat, and the descriptor handshake then opens early or late. The bench compares every sent beat against its own model of the packing in the cycle the beat appears, so such a fault shows within one beat. A fault in the ready-latency delay shows as a beat sent outside the permitted window or as a missing beat in a gapless run. It is caught in the first cycle after the ready pattern changes.

// File: rtl/tlp_tx_pkg.sv
package tlp_tx_pkg;
    localparam int DWORD_W = 32;
    localparam int BEAT_W  = 2 * DWORD_W;
    localparam int HDR_W   = 4 * DWORD_W;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_HDR0,
        PH_HDR1,
        PH_DATA
    } phase_e;

    typedef struct packed {
        logic              sop;
        logic              eop;
        logic [BEAT_W-1:0] data;
    } beat_t;
endpackage

// File: rtl/tlp_tx_rl_gate.sv
// Delays the sink ready by the ready latency; the output opens the beat slot.
module tlp_tx_rl_gate #(
    parameter int LAT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ready_in,
    output logic slot_open
);
    logic [LAT-1:0] dly_q;

    always_ff @(posedge clk) begin
        if (rst) dly_q <= '0;
        else     dly_q <= LAT'({dly_q, ready_in});
    end

    assign slot_open = dly_q[LAT-1];
endmodule

// File: rtl/tlp_tx_beat_mux.sv
// Forms the current beat from the packet phase, latched header and payload.
module tlp_tx_beat_mux
    import tlp_tx_pkg::*;
#(
    parameter int LEN_W = 7
) (
    input  phase_e              phase,
    input  logic [HDR_W-1:0]    hdr,
    input  logic                misaligned,
    input  logic                first_data,
    input  logic [LEN_W-1:0]    remaining,
    input  logic [DWORD_W-1:0]  carry,
    input  logic [BEAT_W-1:0]   pay,
    output beat_t               beat,
    output logic                need_pay,
    output logic [1:0]          n_emit
);
    logic two_left;
    assign two_left = (remaining >= LEN_W'(2));

    always_comb begin
        beat     = '0;
        need_pay = 1'b0;
        n_emit   = 2'd0;
        unique case (phase)
            PH_HDR0: begin
                beat.data = hdr[BEAT_W-1:0];
                beat.sop  = 1'b1;
            end
            PH_HDR1: beat.data = hdr[HDR_W-1:BEAT_W];
            PH_DATA: begin
                if (!misaligned) begin
                    need_pay  = 1'b1;
                    n_emit    = two_left ? 2'd2 : 2'd1;
                    beat.data = {two_left ? pay[BEAT_W-1:DWORD_W] : '0, pay[DWORD_W-1:0]};
                end else if (first_data) begin
                    need_pay  = 1'b1;
                    n_emit    = 2'd1;
                    beat.data = {pay[DWORD_W-1:0], {DWORD_W{1'b0}}};
                end else begin
                    need_pay  = two_left;
                    n_emit    = two_left ? 2'd2 : 2'd1;
                    beat.data = {two_left ? pay[DWORD_W-1:0] : '0, carry};
                end
                beat.eop = (remaining <= LEN_W'(n_emit));
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/tlp_tx_pack.sv
module tlp_tx_pack
    import tlp_tx_pkg::*;
#(
    parameter int MAX_LEN = 64,
    parameter int RDY_LAT = 2,
    localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [HDR_W-1:0]   req_hdr,
    input  logic               req_misaligned,
    input  logic [LEN_W-1:0]   req_len,
    input  logic               pay_valid,
    output logic               pay_ready,
    input  logic [BEAT_W-1:0]  pay_data,
    input  logic               tx_ready,
    output logic               tx_valid,
    output logic               tx_sop,
    output logic               tx_eop,
    output logic [BEAT_W-1:0]  tx_data
);
    phase_e               phase_q;
    logic [HDR_W-1:0]     hdr_q;
    logic                 mis_q;
    logic                 first_q;
    logic [LEN_W-1:0]     rem_q;
    logic [DWORD_W-1:0]   carry_q;

    logic                 slot_open;
    beat_t                beat;
    logic                 need_pay;
    logic [1:0]           n_emit;
    logic                 fire, last_fire, take;

    tlp_tx_rl_gate #(.LAT(RDY_LAT)) u_gate (
        .clk       (clk),
        .rst       (rst),
        .ready_in  (tx_ready),
        .slot_open (slot_open)
    );

    tlp_tx_beat_mux #(.LEN_W(LEN_W)) u_mux (
        .phase      (phase_q),
        .hdr        (hdr_q),
        .misaligned (mis_q),
        .first_data (first_q),
        .remaining  (rem_q),
        .carry      (carry_q),
        .pay        (pay_data),
        .beat       (beat),
        .need_pay   (need_pay),
        .n_emit     (n_emit)
    );

    assign tx_valid  = slot_open && (phase_q != PH_IDLE) && (!need_pay || pay_valid);
    assign fire      = tx_valid;
    assign tx_sop    = fire && beat.sop;
    assign tx_eop    = fire && beat.eop;
    assign tx_data   = beat.data;
    assign pay_ready = fire && need_pay;
    assign last_fire = fire && beat.eop;
    assign req_ready = (phase_q == PH_IDLE) || last_fire;
    assign take      = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            hdr_q   <= '0;
            mis_q   <= 1'b0;
            first_q <= 1'b0;
            rem_q   <= '0;
            carry_q <= '0;
        end else if (take) begin
            phase_q <= PH_HDR0;
            hdr_q   <= req_hdr;
            mis_q   <= req_misaligned;
            first_q <= 1'b1;
            rem_q   <= req_len;
        end else if (last_fire) begin
            phase_q <= PH_IDLE;
        end else if (fire) begin
            unique case (phase_q)
                PH_HDR0: phase_q <= PH_HDR1;
                PH_HDR1: phase_q <= PH_DATA;
                PH_DATA: begin
                    rem_q   <= rem_q - LEN_W'(n_emit);
                    first_q <= 1'b0;
                    if (need_pay) carry_q <= pay_data[BEAT_W-1:DWORD_W];
                end
                default: ;
            endcase
        end
    end

    generate
        if (RDY_LAT == 2) begin : g_win
            // R6
            window_chk: assert property (@(posedge clk) disable iff (rst)
                tx_valid |-> $past(tx_ready, 2));
        end
    endgenerate

    // R10
    pay_fire_chk: assert property (@(posedge clk) disable iff (rst)
        (pay_valid && pay_ready) |-> (tx_valid && phase_q == PH_DATA));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q != PH_IDLE && !tx_valid) |=> ($stable(phase_q) && $stable(rem_q)));

    // R9
    req_take_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |-> (phase_q == PH_IDLE || (tx_valid && tx_eop)));

    // R5
    eop_end_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_eop) |=> (phase_q == PH_IDLE || phase_q == PH_HDR0));

    // R8
    b2b_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_eop && req_valid) |=> (phase_q == PH_HDR0));

    // R12
    len_range_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_len >= LEN_W'(1) && req_len <= LEN_W'(MAX_LEN)));
endmodule

// File: tb/tlp_tx_pack_test.sv
module tlp_tx_pack_test;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [127:0] req_hdr = '0;
    logic         req_misaligned = 1'b0;
    logic [6:0]   req_len = 7'd1;
    logic         pay_valid = 1'b0;
    logic         pay_ready;
    logic [63:0]  pay_data = '0;
    logic         tx_ready = 1'b0;
    logic         tx_valid, tx_sop, tx_eop;
    logic [63:0]  tx_data;

    int n_chk = 0;
    int n_fail = 0;
    int gcyc = 0;
    logic rh1 = 1'b0, rh2 = 1'b0;

    always #5 clk = ~clk;

    always @(posedge clk) begin
        rh2 <= rh1;
        rh1 <= tx_ready;
    end

    tlp_tx_pack uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_hdr(req_hdr),
        .req_misaligned(req_misaligned), .req_len(req_len),
        .pay_valid(pay_valid), .pay_ready(pay_ready), .pay_data(pay_data),
        .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_sop(tx_sop),
        .tx_eop(tx_eop), .tx_data(tx_data)
    );

    // {misaligned, length, expected beat count}
    localparam int NV = 15;
    localparam logic [15:0] VEC [NV] = '{
        {1'b0, 7'd1,  8'd3},  {1'b1, 7'd1,  8'd3},  {1'b0, 7'd2,  8'd3},
        {1'b1, 7'd2,  8'd4},  {1'b0, 7'd3,  8'd4},  {1'b1, 7'd3,  8'd4},
        {1'b0, 7'd4,  8'd4},  {1'b1, 7'd4,  8'd5},  {1'b0, 7'd64, 8'd34},
        {1'b1, 7'd64, 8'd35}, {1'b1, 7'd7,  8'd6},  {1'b0, 7'd7,  8'd6},
        {1'b1, 7'd5,  8'd5},  {1'b0, 7'd63, 8'd34}, {1'b1, 7'd63, 8'd34}
    };

    function automatic logic [31:0] hdr_of(int tag, int i);
        return {8'hA5, 8'(tag), 8'h00, 8'(i)};
    endfunction

    function automatic logic [31:0] dw_of(int tag, int i);
        return {8'h5A, 8'(tag), 16'(i)};
    endfunction

    function automatic logic [63:0] exp_beat(int tag, bit mis, int len, int b);
        logic [31:0] lo, hi;
        int k;
        if (b == 0) return {hdr_of(tag, 1), hdr_of(tag, 0)};
        if (b == 1) return {hdr_of(tag, 3), hdr_of(tag, 2)};
        k = b - 2;
        if (!mis) begin
            lo = dw_of(tag, 2*k);
            hi = (2*k+1 < len) ? dw_of(tag, 2*k+1) : 32'h0;
        end else if (k == 0) begin
            lo = 32'h0;
            hi = dw_of(tag, 0);
        end else begin
            lo = dw_of(tag, 2*k-1);
            hi = (2*k < len) ? dw_of(tag, 2*k) : 32'h0;
        end
        return {hi, lo};
    endfunction

    function automatic bit rdy_pat(int mode, int c);
        if (mode == 1) return (c % 5) < 3;
        if (mode == 2) return ((c * 7) % 11) < 6;
        return 1'b1;
    endfunction

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_stream(int base, int rmode, int pmode);
        int acc, done, beat, pp, pj, cyc, t, len, nb;
        bit mis, seen_sop, idle_before;
        logic [63:0] ed;
        logic [31:0] lo, hi;
        acc = 0; done = 0; beat = 0; pp = 0; pj = 0; cyc = 0; seen_sop = 0;
        while (done < NV) begin
            @(negedge clk);
            tx_ready = rdy_pat(rmode, gcyc);
            if (acc < NV) begin
                t = base + acc;
                req_valid      = 1'b1;
                req_hdr        = {hdr_of(t, 3), hdr_of(t, 2), hdr_of(t, 1), hdr_of(t, 0)};
                req_misaligned = VEC[acc][15];
                req_len        = VEC[acc][14:8];
            end else begin
                req_valid = 1'b0;
            end
            if (pp < NV) begin
                t   = base + pp;
                len = int'(VEC[pp][14:8]);
                lo  = dw_of(t, 2*pj);
                hi  = (2*pj+1 < len) ? dw_of(t, 2*pj+1) : 32'hDEADBEEF;
                pay_data  = {hi, lo};
                pay_valid = !(pmode == 1 && (gcyc % 4) == 3);
            end else begin
                pay_valid = 1'b0;
            end
            #2;
            idle_before = (acc == done);
            // R6
            check(!tx_valid || rh2, "R6 beat outside ready window", 64'(tx_valid), 64'(rh2));
            // R9
            check(req_ready == (idle_before || (tx_valid && tx_eop)), "R9 req_ready",
                  64'(req_ready), 64'(idle_before || (tx_valid && tx_eop)));
            // R10
            check(!pay_ready || tx_valid, "R10 payload taken without beat",
                  64'(pay_ready), 64'(tx_valid));
            if (rmode == 0 && pmode == 0 && seen_sop)
                check(tx_valid, "R8 gap in back-to-back stream", 64'(tx_valid), 64'd1);
            if (tx_valid) begin
                t   = base + done;
                mis = VEC[done][15];
                len = int'(VEC[done][14:8]);
                nb  = int'(VEC[done][7:0]);
                ed  = exp_beat(t, mis, len, beat);
                if (beat == 0)      check(tx_data == ed, "R1 header beat 0", tx_data, ed);
                else if (beat == 1) check(tx_data == ed, "R2 header beat 1", tx_data, ed);
                else if (!mis)      check(tx_data == ed, "R3 aligned data beat", tx_data, ed);
                else                check(tx_data == ed, "R4 misaligned data beat", tx_data, ed);
                // R5 and R7: markers at the expected position in order
                check(tx_sop == (beat == 0) && tx_eop == (beat == nb-1), "R5 R7 sop/eop position",
                      {62'd0, tx_sop, tx_eop}, {62'd0, 1'(beat == 0), 1'(beat == nb-1)});
                seen_sop = 1'b1;
                if (beat == nb-1) begin
                    done++;
                    beat = 0;
                end else begin
                    beat++;
                end
            end
            if (req_valid && req_ready) acc++;
            if (pay_valid && pay_ready) begin
                pj++;
                if (pj == (int'(VEC[pp][14:8]) + 1) / 2) begin
                    pp++;
                    pj = 0;
                end
            end
            cyc++;
            gcyc++;
            if (cyc > 20000) begin
                check(1'b0, "watchdog expired", 64'(done), 64'(NV));
                break;
            end
        end
        @(negedge clk);
        req_valid = 1'b0;
        pay_valid = 1'b0;
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        #2;
        // R11
        check(!tx_valid && !pay_ready && req_ready, "R11 state in reset",
              {61'd0, tx_valid, pay_ready, req_ready}, 64'd1);
        @(negedge clk);
        rst = 1'b0;
        tx_ready = 1'b1;
        req_valid = 1'b1;
        req_hdr = '0;
        req_len = 7'd1;
        pay_valid = 1'b1;
        #2;
        check(!tx_valid, "R6 no beat right after reset", 64'(tx_valid), 64'd0);
        check(!pay_ready, "R11 pay_ready after reset", 64'(pay_ready), 64'd0);
        req_valid = 1'b0;
        pay_valid = 1'b0;
        @(negedge clk);
        #2;
        check(!tx_valid, "R6 no beat second cycle after reset", 64'(tx_valid), 64'd0);
        check(req_ready, "R11 req_ready idle after reset", 64'(req_ready), 64'd1);

        run_stream(0,  1, 0);
        run_stream(16, 2, 1);
        run_stream(32, 0, 0);
        run_stream(48, 2, 0);

        repeat (3) @(negedge clk);
        #2;
        check(!tx_valid && req_ready, "R9 idle after final packet",
              {62'd0, tx_valid, req_ready}, 64'd1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule